// File: doc/BRIEF.md
# Masked Peripheral Register File

This block is the byte-wide I/O register page of a small handheld-style system. A CPU bus presents an address, write data, a write strobe and a read strobe. The block keeps the stored byte of each implemented register, and on reads it sets every unimplemented bit to 1 through a constant mask chosen by the address. Addresses that decode to no register read as 0xFF.

Writes follow per-register rules. The interrupt-flag byte always keeps its top three bits set on write, and peripherals can raise its low five bits at any time. Sound registers are gated by a master sound-enable bit. While that bit is clear, a write is dropped and the stored byte becomes zero. The older hardware variant, selected by a parameter, still passes length writes through in that state. The master sound-control byte takes only its power bit from the bus, and the display-status byte merges live mode bits into its read value. The timer, sound, video and DMA engines behind the page are not part of this block. They see it only through registered side-band pulses and a few status inputs.

Top module: `io_regfile`

## Requirements
- R1: A read of an implemented register returns its stored byte ORed with its fixed mask: timer control 0x07 mask 0xF8, interrupt flag 0x0F mask 0xE0, interrupt enable 0xFF mask 0xE0, pulse-1 length 0x11 mask 0x3F, pulse-1 envelope 0x12 mask 0x00, pulse-2 length 0x16 mask 0x3F, pulse-2 envelope 0x17 mask 0x00, wave length 0x1B mask 0xFF, noise length 0x20 mask 0xFF, noise envelope 0x21 mask 0x00, master volume 0x24 mask 0x00, panning 0x25 mask 0x00, sound control 0x26 mask 0x70, display control 0x40 mask 0x00, background palette 0x47 mask 0x00.
- R2: `rdata` is 0xFF when `rd_en` is low, and also for any address not listed in R1, R9 or R11 (for example 0x30 or 0x80).
- R3: A write to 0x0F stores the written byte ORed with 0xE0. Each cycle, every set bit of `irq_set[4:0]` also sets the matching bit of that register.
- R4: `irq` is high exactly when bits 4:0 of the interrupt-flag and interrupt-enable bytes share a set bit. Bits 7:5 never raise it.
- R5: While sound-control bit 7 is 1, a write to a sound register (0x11 to 0x25 as listed in R1) stores the byte and forwards it on the side-band.
- R6: While sound-control bit 7 is 0, a write to a sound register stores 0 and forwards nothing. The exceptions are given in R7.
- R7: When `LEGACY_SND` is 1 and sound is disabled, writes to wave length 0x1B and noise length 0x20 are still stored and forwarded unchanged. Writes to pulse lengths 0x11 and 0x16 store 0 but are forwarded ANDed with 0x3F. When `LEGACY_SND` is 0, R6 applies to these registers too.
- R8: A write to sound control 0x26 is always forwarded. It takes bit 7 from the bus, clears bits 6:4, and keeps the stored bits 3:0. Bit 7 is the master sound-enable.
- R9: A write to 0x04 stores nothing and raises `div_rst` as a one-cycle pulse. A read of 0x04 returns `div_val` unmasked.
- R10: After reset, interrupt flag reads 0xE1, sound control 0xF1, display control 0x91, background palette 0xFC, and every other stored byte is 0x00.
- R11: Display status 0x41 stores bits 6:3 of a write. A read returns bit 7 as 1, the stored bits 6:3, and the live `vid_mode[2:0]` in bits 2:0.
- R12: Side-band outputs are registered. They are valid for the one cycle after the clock edge that takes the write. `snd_addr` and `snd_data` are zero whenever `snd_wr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 8 | Register address within the page |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| rd_en | input | 1 | Read strobe; read data is combinational |
| rdata | output | 8 | Read data |
| irq_set | input | 5 | Peripheral interrupt-request set bits |
| vid_mode | input | 3 | Live display mode bits for the status read |
| div_val | input | 8 | Live divider count for reads of 0x04 |
| irq | output | 1 | Interrupt request to the CPU |
| div_rst | output | 1 | Divider reset pulse |
| snd_wr | output | 1 | Sound register write pulse |
| snd_addr | output | 8 | Address of the forwarded sound write |
| snd_data | output | 8 | Forwarded sound write data |

## Verification
The bench builds two copies side by side and drives both with the same stimulus. One copy has `LEGACY_SND` set to 1 and the other has it set to 0. Only the legacy copy may forward length writes while sound is off, so comparing their side-band outputs on the same write exposes that variant rule directly. The rest of the register behaviour is identical in both copies, and the checks read it back through the default legacy instance.

// File: rtl/io_regs_pkg.sv
`timescale 1ns/1ps
package io_regs_pkg;

  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 8;
  localparam int NUM_STORED = 16;
  localparam int IDX_W      = $clog2(NUM_STORED);
  localparam int IRQ_LINES  = 5;
  localparam int MODE_W     = 3;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // storage slots
  localparam idx_t IX_TCTL  = idx_t'(0);
  localparam idx_t IX_IFLG  = idx_t'(1);
  localparam idx_t IX_P1LEN = idx_t'(2);
  localparam idx_t IX_P1ENV = idx_t'(3);
  localparam idx_t IX_P2LEN = idx_t'(4);
  localparam idx_t IX_P2ENV = idx_t'(5);
  localparam idx_t IX_WLEN  = idx_t'(6);
  localparam idx_t IX_NLEN  = idx_t'(7);
  localparam idx_t IX_NENV  = idx_t'(8);
  localparam idx_t IX_MVOL  = idx_t'(9);
  localparam idx_t IX_PAN   = idx_t'(10);
  localparam idx_t IX_SCTL  = idx_t'(11);
  localparam idx_t IX_LCTL  = idx_t'(12);
  localparam idx_t IX_LSTAT = idx_t'(13);
  localparam idx_t IX_BGPAL = idx_t'(14);
  localparam idx_t IX_IEN   = idx_t'(15);

  // bus addresses
  localparam addr_t AD_DIVR  = 8'h04;
  localparam addr_t AD_TCTL  = 8'h07;
  localparam addr_t AD_IFLG  = 8'h0F;
  localparam addr_t AD_P1LEN = 8'h11;
  localparam addr_t AD_P1ENV = 8'h12;
  localparam addr_t AD_P2LEN = 8'h16;
  localparam addr_t AD_P2ENV = 8'h17;
  localparam addr_t AD_WLEN  = 8'h1B;
  localparam addr_t AD_NLEN  = 8'h20;
  localparam addr_t AD_NENV  = 8'h21;
  localparam addr_t AD_MVOL  = 8'h24;
  localparam addr_t AD_PAN   = 8'h25;
  localparam addr_t AD_SCTL  = 8'h26;
  localparam addr_t AD_LCTL  = 8'h40;
  localparam addr_t AD_LSTAT = 8'h41;
  localparam addr_t AD_BGPAL = 8'h47;
  localparam addr_t AD_IEN   = 8'hFF;

  localparam byte_t IFLG_HIGH      = 8'hE0;
  localparam byte_t PULSE_LEN_MASK = 8'h3F;

  typedef enum logic [2:0] {
    K_NONE, K_PLAIN, K_SOUND, K_SCTL, K_IFLG, K_STAT, K_DIV
  } kind_e;

  typedef struct packed {
    kind_e kind;
    idx_t  idx;
    byte_t mask;
    logic  len_full;
    logic  len_pulse;
  } dec_t;

  function automatic byte_t reset_value(idx_t i);
    case (i)
      IX_IFLG:  return 8'h01;
      IX_SCTL:  return 8'hF1;
      IX_LCTL:  return 8'h91;
      IX_BGPAL: return 8'hFC;
      default:  return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/io_rst_sync.sv
`timescale 1ns/1ps
module io_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/io_addr_decode.sv
`timescale 1ns/1ps
module io_addr_decode
  import io_regs_pkg::*;
(
  input  addr_t addr,
  output dec_t  dec
);
  function automatic dec_t mk(kind_e k, idx_t i, byte_t m, logic f, logic p);
    dec_t r;
    r.kind = k; r.idx = i; r.mask = m; r.len_full = f; r.len_pulse = p;
    return r;
  endfunction

  always_comb begin
    case (addr)
      AD_DIVR:  dec = mk(K_DIV,   '0,       8'h00, 1'b0, 1'b0);
      AD_TCTL:  dec = mk(K_PLAIN, IX_TCTL,  8'hF8, 1'b0, 1'b0);
      AD_IFLG:  dec = mk(K_IFLG,  IX_IFLG,  8'hE0, 1'b0, 1'b0);
      AD_P1LEN: dec = mk(K_SOUND, IX_P1LEN, 8'h3F, 1'b0, 1'b1);
      AD_P1ENV: dec = mk(K_SOUND, IX_P1ENV, 8'h00, 1'b0, 1'b0);
      AD_P2LEN: dec = mk(K_SOUND, IX_P2LEN, 8'h3F, 1'b0, 1'b1);
      AD_P2ENV: dec = mk(K_SOUND, IX_P2ENV, 8'h00, 1'b0, 1'b0);
      AD_WLEN:  dec = mk(K_SOUND, IX_WLEN,  8'hFF, 1'b1, 1'b0);
      AD_NLEN:  dec = mk(K_SOUND, IX_NLEN,  8'hFF, 1'b1, 1'b0);
      AD_NENV:  dec = mk(K_SOUND, IX_NENV,  8'h00, 1'b0, 1'b0);
      AD_MVOL:  dec = mk(K_SOUND, IX_MVOL,  8'h00, 1'b0, 1'b0);
      AD_PAN:   dec = mk(K_SOUND, IX_PAN,   8'h00, 1'b0, 1'b0);
      AD_SCTL:  dec = mk(K_SCTL,  IX_SCTL,  8'h70, 1'b0, 1'b0);
      AD_LCTL:  dec = mk(K_PLAIN, IX_LCTL,  8'h00, 1'b0, 1'b0);
      AD_LSTAT: dec = mk(K_STAT,  IX_LSTAT, 8'h80, 1'b0, 1'b0);
      AD_BGPAL: dec = mk(K_PLAIN, IX_BGPAL, 8'h00, 1'b0, 1'b0);
      AD_IEN:   dec = mk(K_PLAIN, IX_IEN,   8'hE0, 1'b0, 1'b0);
      default:  dec = mk(K_NONE,  '0,       8'hFF, 1'b0, 1'b0);
    endcase
  end
endmodule

// File: rtl/io_reg_bank.sv
`timescale 1ns/1ps
module io_reg_bank
  import io_regs_pkg::*;
#(
  parameter bit LEGACY_SND = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  addr_t                addr,
  input  byte_t                wdata,
  input  kind_e                kind,
  input  idx_t                 idx,
  input  logic                 len_full,
  input  logic                 len_pulse,
  input  logic [IRQ_LINES-1:0] irq_set,
  output byte_t                rd_byte,
  output byte_t                iflg,
  output byte_t                ien,
  output logic                 snd_wr,
  output addr_t                snd_addr,
  output byte_t                snd_data,
  output logic                 div_rst
);
  logic [NUM_STORED-1:0][DATA_W-1:0] regs_q;
  logic [NUM_STORED-1:0][DATA_W-1:0] regs_d;
  logic [NUM_STORED-1:0]             reg_we;

  logic  snd_en;
  logic  keep_full, keep_pulse;
  logic  fwd, div_hit;
  byte_t fwd_data;

  logic  snd_wr_q, div_rst_q;
  addr_t snd_addr_q;
  byte_t snd_data_q;
  logic  snd_wr_d, div_rst_d;
  addr_t snd_addr_d;
  byte_t snd_data_d;

  assign snd_en = regs_q[IX_SCTL][7];

  // variant choice for writes while sound is off
  generate
    if (LEGACY_SND) begin : g_legacy
      assign keep_full  = len_full;
      assign keep_pulse = len_pulse;
    end else begin : g_strict
      assign keep_full  = 1'b0;
      assign keep_pulse = 1'b0;
    end
  endgenerate

  // next-state logic
  always_comb begin
    regs_d   = regs_q;
    reg_we   = '0;
    fwd      = 1'b0;
    fwd_data = wdata;
    div_hit  = 1'b0;
    if (|irq_set) begin
      regs_d[IX_IFLG] = regs_q[IX_IFLG] | byte_t'(irq_set);
      reg_we[IX_IFLG] = 1'b1;
    end
    if (wr_en) begin
      case (kind)
        K_PLAIN: begin
          regs_d[idx] = wdata;
          reg_we[idx] = 1'b1;
        end
        K_IFLG: begin
          regs_d[IX_IFLG] = wdata | IFLG_HIGH | byte_t'(irq_set);
          reg_we[IX_IFLG] = 1'b1;
        end
        K_STAT: begin
          regs_d[IX_LSTAT] = {1'b0, wdata[6:3], 3'b000};
          reg_we[IX_LSTAT] = 1'b1;
        end
        K_SCTL: begin
          regs_d[IX_SCTL] = {wdata[7], 3'b000, regs_q[IX_SCTL][3:0]};
          reg_we[IX_SCTL] = 1'b1;
          fwd             = 1'b1;
        end
        K_SOUND: begin
          reg_we[idx] = 1'b1;
          if (snd_en || keep_full) begin
            regs_d[idx] = wdata;
            fwd         = 1'b1;
          end else begin
            regs_d[idx] = '0;
            if (keep_pulse) begin
              fwd      = 1'b1;
              fwd_data = wdata & PULSE_LEN_MASK;
            end
          end
        end
        K_DIV:   div_hit = 1'b1;
        default: ;
      endcase
    end
  end

  // storage, one enabled register per slot
  generate
    for (genvar g = 0; g < NUM_STORED; g++) begin : g_slot
      byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= reset_value(idx_t'(g));
        else if (reg_we[g]) q <= regs_d[g];
      end
      assign regs_q[g] = q;
    end
  endgenerate

  // side-band next state
  always_comb begin
    snd_wr_d   = fwd;
    snd_addr_d = fwd ? addr : '0;
    snd_data_d = fwd ? fwd_data : '0;
    div_rst_d  = div_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snd_wr_q   <= 1'b0;
      snd_addr_q <= '0;
      snd_data_q <= '0;
      div_rst_q  <= 1'b0;
    end else begin
      snd_wr_q   <= snd_wr_d;
      snd_addr_q <= snd_addr_d;
      snd_data_q <= snd_data_d;
      div_rst_q  <= div_rst_d;
    end
  end

  assign rd_byte  = regs_q[idx];
  assign iflg     = regs_q[IX_IFLG];
  assign ien      = regs_q[IX_IEN];
  assign snd_wr   = snd_wr_q;
  assign snd_addr = snd_addr_q;
  assign snd_data = snd_data_q;
  assign div_rst  = div_rst_q;

  // R3
  if_high_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && kind == K_IFLG) |-> regs_q[IX_IFLG][7:5] == 3'b111);

  // R6
  snd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && kind == K_SOUND && !snd_en && !len_full && !len_pulse)
      |-> (!snd_wr_q && regs_q[$past(idx)] == '0));

  // R7
  pulse_len_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_wr_q && $past(!snd_en && len_pulse && kind == K_SOUND))
      |-> snd_data_q[7:6] == 2'b00);

  // R8
  sctl_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && kind == K_SCTL)
      |-> regs_q[IX_SCTL][3:0] == $past(regs_q[IX_SCTL][3:0]));

  // R9
  div_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst_q |-> $past(wr_en && kind == K_DIV));

endmodule

// File: rtl/io_regfile.sv
`timescale 1ns/1ps
module io_regfile
  import io_regs_pkg::*;
#(
  parameter bit LEGACY_SND = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [DATA_W-1:0]    rdata,
  input  logic [IRQ_LINES-1:0] irq_set,
  input  logic [MODE_W-1:0]    vid_mode,
  input  logic [DATA_W-1:0]    div_val,
  output logic                 irq,
  output logic                 div_rst,
  output logic                 snd_wr,
  output logic [ADDR_W-1:0]    snd_addr,
  output logic [DATA_W-1:0]    snd_data
);
  logic  rst_sync_n;
  dec_t  dec;
  byte_t rd_byte, iflg, ien;

  io_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  io_addr_decode u_dec (
    .addr (addr),
    .dec  (dec)
  );

  io_reg_bank #(.LEGACY_SND(LEGACY_SND)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .kind      (dec.kind),
    .idx       (dec.idx),
    .len_full  (dec.len_full),
    .len_pulse (dec.len_pulse),
    .irq_set   (irq_set),
    .rd_byte   (rd_byte),
    .iflg      (iflg),
    .ien       (ien),
    .snd_wr    (snd_wr),
    .snd_addr  (snd_addr),
    .snd_data  (snd_data),
    .div_rst   (div_rst)
  );

  always_comb begin
    if (!rd_en) begin
      rdata = 8'hFF;
    end else begin
      case (dec.kind)
        K_NONE:  rdata = 8'hFF;
        K_DIV:   rdata = div_val;
        K_STAT:  rdata = {1'b1, rd_byte[6:3], vid_mode};
        default: rdata = rd_byte | dec.mask;
      endcase
    end
  end

  assign irq = |(iflg[IRQ_LINES-1:0] & ien[IRQ_LINES-1:0]);

  // R2
  unknown_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && dec.kind == K_NONE) |-> rdata == 8'hFF);

  // R4
  irq_low_lines_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> ((iflg[4:0] & ien[4:0]) != 5'd0));

endmodule

// File: tb/io_regfile_tb.sv
`timescale 1ns/1ps
module io_regfile_tb_top;

  logic       clk;
  logic       rst_n;
  logic [7:0] addr, wdata;
  logic       wr_en, rd_en;
  logic [4:0] irq_set;
  logic [2:0] vid_mode;
  logic [7:0] div_val;

  logic [7:0] rdata, snd_addr, snd_data;
  logic       irq, div_rst, snd_wr;
  logic [7:0] rdata_b, snd_addr_b, snd_data_b;
  logic       irq_b, div_rst_b, snd_wr_b;

  io_regfile #(.LEGACY_SND(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .irq_set(irq_set), .vid_mode(vid_mode),
    .div_val(div_val), .irq(irq), .div_rst(div_rst), .snd_wr(snd_wr),
    .snd_addr(snd_addr), .snd_data(snd_data));

  io_regfile #(.LEGACY_SND(1'b0)) dut_new_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata_b), .irq_set(irq_set), .vid_mode(vid_mode),
    .div_val(div_val), .irq(irq_b), .div_rst(div_rst_b), .snd_wr(snd_wr_b),
    .snd_addr(snd_addr_b), .snd_data(snd_data_b));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // scoreboard: kind 0 rdata, 1 irq, 2 side-band, 3 side-band second copy, 4 rdata second copy
  time         due_q[$];
  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [31:0] side(logic d, logic w, logic [7:0] a, logic [7:0] x);
    return {14'd0, d, w, a, x};
  endfunction

  task automatic push(time due, int kind, logic [31:0] e, string tag);
    due_q.push_back(due); kind_q.push_back(kind);
    exp_q.push_back(e);   tag_q.push_back(tag);
  endtask

  // monitor
  always begin
    @(negedge clk);
    #5;
    while (due_q.size() > 0 && due_q[0] == $time) begin
      logic [31:0] act;
      int          k;
      logic [31:0] e;
      string       t;
      k = kind_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      void'(due_q.pop_front());
      case (k)
        0:       act = {24'd0, rdata};
        1:       act = {31'd0, irq};
        2:       act = side(div_rst, snd_wr, snd_addr, snd_data);
        3:       act = side(div_rst_b, snd_wr_b, snd_addr_b, snd_data_b);
        default: act = {24'd0, rdata_b};
      endcase
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, act, e);
      end
    end
  end

  // driver tasks, each entered right after a falling edge
  task automatic rd(logic [7:0] a, logic [7:0] e, string tag);
    addr = a; rd_en = 1'b1;
    push($time + 5, 0, {24'd0, e}, tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_b(logic [7:0] a, logic [7:0] e, string tag);
    addr = a; rd_en = 1'b1;
    push($time + 5, 4, {24'd0, e}, tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, logic [31:0] e_side, string tag);
    addr = a; wdata = d; wr_en = 1'b1;
    push($time + 25, 2, e_side, tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr2(logic [7:0] a, logic [7:0] d, logic [31:0] e1, logic [31:0] e2,
                     string tag);
    addr = a; wdata = d; wr_en = 1'b1;
    push($time + 25, 2, e1, tag);
    push($time + 25, 3, e2, tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_irq(logic e, string tag);
    push($time + 5, 1, {31'd0, e}, tag);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    irq_set = '0; vid_mode = 3'b010; div_val = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 strobe low
    addr = 8'h0F;
    push($time + 5, 0, 32'hFF, "R2 rd_en low");
    @(negedge clk);
    // R10 reset values
    rd(8'h0F, 8'hE1, "R10 iflg");
    rd(8'h26, 8'hF1, "R10 sctl");
    rd(8'h40, 8'h91, "R10 lctl");
    rd(8'h47, 8'hFC, "R10 bgpal");
    rd(8'h07, 8'hF8, "R1 R10 tctl");
    rd(8'hFF, 8'hE0, "R1 R10 ien");
    rd(8'h41, 8'h82, "R11 lstat reset");
    chk_irq(1'b0, "R4 reset irq");
    rd(8'h30, 8'hFF, "R2 unknown 30");
    rd(8'h80, 8'hFF, "R2 unknown 80");

    wr(8'h07, 8'h05, 32'd0, "R12 tctl no side");
    rd(8'h07, 8'hFD, "R1 tctl mask");
    wr(8'h41, 8'h78, 32'd0, "R12 lstat no side");
    rd(8'h41, 8'hFA, "R11 lstat merge");
    vid_mode = 3'b101;
    rd(8'h41, 8'hFD, "R11 live mode");

    wr(8'h0F, 8'h02, 32'd0, "R12 iflg no side");
    rd(8'h0F, 8'hE2, "R3 iflg or");
    chk_irq(1'b0, "R4 no enable");
    wr(8'hFF, 8'h02, 32'd0, "R12 ien no side");
    chk_irq(1'b1, "R4 match");
    rd(8'hFF, 8'hE2, "R1 ien mask");
    wr(8'hFF, 8'hE0, 32'd0, "R12 ien high");
    chk_irq(1'b0, "R4 high bits ignored");
    irq_set = 5'b00001;
    @(negedge clk);
    irq_set = '0;
    rd(8'h0F, 8'hE3, "R3 peripheral set");
    wr(8'hFF, 8'h01, 32'd0, "R12 ien bit0");
    chk_irq(1'b1, "R4 set line");
    wr(8'h0F, 8'h00, 32'd0, "R12 iflg clear");
    rd(8'h0F, 8'hE0, "R3 cleared");
    chk_irq(1'b0, "R4 cleared");

    wr(8'h12, 8'hA5, side(0, 1, 8'h12, 8'hA5), "R5 R12 env fwd");
    rd(8'h12, 8'hA5, "R5 env store");
    wr(8'h24, 8'h77, side(0, 1, 8'h24, 8'h77), "R5 vol fwd");
    rd(8'h24, 8'h77, "R5 vol store");
    wr(8'h04, 8'h99, side(1, 0, 8'h00, 8'h00), "R9 div pulse");
    rd(8'h04, 8'h3C, "R9 div read");

    wr(8'h26, 8'h0F, side(0, 1, 8'h26, 8'h0F), "R8 sctl fwd");
    rd(8'h26, 8'h71, "R8 sctl off");
    wr(8'h12, 8'hFF, 32'd0, "R6 env gated");
    rd(8'h12, 8'h00, "R6 env zero");
    wr(8'h25, 8'h33, 32'd0, "R6 pan gated");
    rd(8'h25, 8'h00, "R6 pan zero");
    wr2(8'h1B, 8'h9A, side(0, 1, 8'h1B, 8'h9A), 32'd0, "R7 wave len");
    rd(8'h1B, 8'hFF, "R1 wave len mask");
    wr2(8'h11, 8'hFF, side(0, 1, 8'h11, 8'h3F), 32'd0, "R7 pulse len");
    rd(8'h11, 8'h3F, "R7 pulse len stored zero");
    rd_b(8'h11, 8'h3F, "R7 second copy pulse len");
    wr2(8'h20, 8'h44, side(0, 1, 8'h20, 8'h44), 32'd0, "R7 noise len");

    wr(8'h26, 8'h80, side(0, 1, 8'h26, 8'h80), "R8 sctl on");
    rd(8'h26, 8'hF1, "R8 sctl nibble kept");
    wr(8'h12, 8'h5A, side(0, 1, 8'h12, 8'h5A), "R5 reenabled");
    rd(8'h12, 8'h5A, "R5 reenabled store");

    repeat (4) @(negedge clk);
    if (due_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d expected 0 pending", due_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule